// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block writes a byte image into a one-time-programmable memory array with a pulse-then-check loop. A start request latches a first and a last address. For each address in ascending order it fetches the intended byte from a source port. It holds chip-enable low with the address and data steady, and drives one timed low strobe on the program line. It then reads the cell back and compares it against the intended byte. A mismatch earns another strobe. When the retry budget is spent without a match, the run stops with a failure.

Once the last address matches, a level flag drops from programming supply to normal read supply. The sequencer then walks the whole range again, read-only, comparing every byte with the source. A single mismatch in this pass ends the run in failure. A clean pass ends it in success. The usual image spans the full array. A run whose first and last addresses are the same, such as burning a lock byte of FE hex at address zero, touches one cell only.

Source-port handshake: `src_req` stays high with `src_addr` until the responder raises `src_ack`. On that cycle the sequencer takes `src_data`. Memory read data is sampled at the end of the single cycle in which `mem_oe_n` is low. The first address must not be above the last address.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset `busy`, `pass`, `fail`, `prog_level` and `src_req` are 0, and `mem_ce_n`, `mem_oe_n`, `mem_pgm_n` are 1.
- R2: Every program strobe holds `mem_pgm_n` low for exactly round(CLK_HZ × PULSE_US / 10^6) clock cycles. With the defaults this is 100 µs, inside the accepted window of 95 to 105 µs.
- R3: `mem_ce_n` is low and `mem_oe_n` is high while `mem_pgm_n` is low. `mem_ce_n` is low, with the same address and data, for at least one cycle before the strobe falls and in the cycle after it rises. Address and data never change while the strobe is low.
- R4: Each strobe is followed by a read-back. A mismatch is followed by another strobe, so an address whose cell takes k strobes to settle (k ≤ MAX_TRIES) receives exactly k strobes.
- R5: If a cell still mismatches after MAX_TRIES (default 25) strobes, the run ends with `fail` = 1, and no later address receives a strobe or a verify read.
- R6: Addresses are visited in ascending order from the first to the last address. A run whose first and last addresses are equal strobes only that one address.
- R7: `prog_level` is 1 during every strobe and during the whole programming phase. It is 0 for the final pass, in which no strobe occurs.
- R8: The final pass reads each address of the range once, in order. The first mismatch ends the run with `fail` = 1. If every byte matches, the run ends with `pass` = 1.
- R9: `busy` rises on the cycle after an accepted start and falls when `pass` or `fail` is set. A start pulse while `busy` is 1 changes neither the range nor the result.
- R10: `pass` and `fail` are never both 1. Each holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| start_addr | input | AW | First address of the range |
| end_addr | input | AW | Last address of the range |
| src_req | output | 1 | Source byte request |
| src_addr | output | AW | Address of requested source byte |
| src_ack | input | 1 | Source byte valid |
| src_data | input | 8 | Source byte |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory program data |
| mem_rdata | input | 8 | Memory read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| prog_level | output | 1 | 1 = programming supply, 0 = read supply |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Run finished successfully |
| fail | output | 1 | Run finished with error |

## Verification
A wrong retry count shows up within a single address. The number of strobes the memory model sees for that cell departs from the number it needs, and the result flag flips as soon as the limit is reached. A pulse timer that loads or counts wrongly shows on the first strobe of the first run as a wrong low-width. An address walker that skips, repeats or fails to rewind leaves strobe counts or verify read counts that differ from the range. A level flag that drops early puts a strobe under read level, and this is seen on the next strobe.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_READ, S_CHECK,
    S_VFETCH, S_VREAD, S_VCHECK
  } seq_state_t;

  // strobe length in clock cycles, rounded to nearest, never below one
  function automatic int pulse_cycles(input int clk_hz, input int pulse_us);
    int c;
    c = ((clk_hz / 1000) * pulse_us + 500) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= RELOAD;
    else if (run && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);

  AST_TIMER_LOAD_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && run)); // R2
endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
  parameter int MAX_TRIES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic limit_hit
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] LIMIT = TW'(MAX_TRIES);

  logic [TW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign limit_hit = (count == LIMIT);

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (count < LIMIT)); // R5
endmodule

// File: rtl/otp_addr_walk.sv
module otp_addr_walk #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          rewind,
  input  logic          step,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  logic [AW-1:0] first_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      addr    <= '0;
    end else if (load) begin
      first_q <= first_addr;
      last_q  <= last_addr;
      addr    <= first_addr;
    end else if (rewind) begin
      addr <= first_q;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  assign at_last = (addr == last_q);

  AST_WALK_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_last); // R6
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_seq_pkg::*;
#(
  parameter int AW        = 17,
  parameter int CLK_HZ    = 10_000_000,
  parameter int PULSE_US  = 100,
  parameter int MAX_TRIES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          src_req,
  output logic [AW-1:0] src_addr,
  input  logic          src_ack,
  input  logic [7:0]    src_data,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_pgm_n,
  output logic          prog_level,
  output logic          busy,
  output logic          pass,
  output logic          fail
);
  localparam int PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_US);

  seq_state_t    state;
  logic [7:0]    want_q, got_q;
  logic [AW-1:0] addr;

  // named internal events
  logic accept_start, pulse_done, byte_match, at_last, tries_spent;
  logic walk_rewind, walk_step;

  assign accept_start = (state == S_IDLE) && start;
  assign byte_match   = (got_q == want_q);
  assign walk_rewind  = (state == S_CHECK) && byte_match && at_last;
  assign walk_step    = ((state == S_CHECK) || (state == S_VCHECK)) && byte_match && !at_last;

  otp_addr_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(accept_start), .rewind(walk_rewind),
    .step(walk_step), .first_addr(start_addr), .last_addr(end_addr),
    .addr(addr), .at_last(at_last)
  );

  otp_pulse_timer #(.CYCLES(PULSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(state == S_SETUP),
    .run(state == S_PULSE), .done(pulse_done)
  );

  otp_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(state == S_FETCH),
    .inc(state == S_READ), .limit_hit(tries_spent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      want_q     <= '0;
      got_q      <= '0;
      busy       <= 1'b0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      prog_level <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          busy       <= 1'b1;
          pass       <= 1'b0;
          fail       <= 1'b0;
          prog_level <= 1'b1;
          state      <= S_FETCH;
        end
        S_FETCH: if (src_ack) begin
          want_q <= src_data;
          state  <= S_SETUP;
        end
        S_SETUP: state <= S_PULSE;
        S_PULSE: if (pulse_done) state <= S_HOLD;
        S_HOLD:  state <= S_READ;
        S_READ: begin
          got_q <= mem_rdata;
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (byte_match) begin
            if (at_last) begin
              prog_level <= 1'b0;
              state      <= S_VFETCH;
            end else begin
              state <= S_FETCH;
            end
          end else if (tries_spent) begin
            fail  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_SETUP;
          end
        end
        S_VFETCH: if (src_ack) begin
          want_q <= src_data;
          state  <= S_VREAD;
        end
        S_VREAD: begin
          got_q <= mem_rdata;
          state <= S_VCHECK;
        end
        S_VCHECK: begin
          if (!byte_match) begin
            fail  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (at_last) begin
            pass  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_VFETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign src_req   = (state == S_FETCH) || (state == S_VFETCH);
  assign src_addr  = addr;
  assign mem_addr  = addr;
  assign mem_wdata = want_q;
  assign mem_pgm_n = (state != S_PULSE);
  assign mem_oe_n  = !((state == S_READ) || (state == S_VREAD));
  assign mem_ce_n  = !((state == S_SETUP) || (state == S_PULSE) || (state == S_HOLD) ||
                       (state == S_READ)  || (state == S_VREAD));

  AST_STROBE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (!mem_ce_n && mem_oe_n)); // R3
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |=> (mem_pgm_n || ($stable(mem_addr) && $stable(mem_wdata)))); // R3
  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |=> (!mem_ce_n && $stable(mem_addr) && $stable(mem_wdata))); // R3
  AST_STROBE_AT_PROG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> prog_level); // R7
  AST_VERIFY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_level) |-> mem_pgm_n); // R7
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail)); // R10
  AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!pass && !fail)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pass) && $stable(fail))); // R10
endmodule

// File: tb/sim_otp_burn_seq.sv
module sim_otp_burn_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 4;
  localparam int NADDR      = 1 << AW;
  localparam int CLK_HZ     = 100_000;
  localparam int PULSE_US   = 100;
  localparam int MAX_TRIES  = 25;
  // expected strobe width, computed from time: 100 us at 100 kHz
  localparam int EXP_PW     = (CLK_HZ * PULSE_US + 500_000) / 1_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic src_req, src_ack;
  logic [AW-1:0] src_addr, mem_addr;
  logic [7:0] src_data, mem_wdata, mem_rdata;
  logic mem_ce_n, mem_oe_n, mem_pgm_n, prog_level, busy, pass, fail;

  always #(CLK_PERIOD / 2) clk = ~clk;

  otp_burn_seq #(.AW(AW), .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US), .MAX_TRIES(MAX_TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .src_req(src_req), .src_addr(src_addr), .src_ack(src_ack), .src_data(src_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
    .prog_level(prog_level), .busy(busy), .pass(pass), .fail(fail)
  );

  // image source and memory model
  logic [7:0] img [NADDR];
  logic [7:0] mem [NADDR];
  int need [NADDR];
  int pcount [NADDR];
  int lowrun, bad_width, bad_stab, bad_level, vreads;
  logic clr_model = 1'b0, disturb_en = 1'b0;
  logic prev_pgm, prev_ce, prev_lvl;
  logic [AW-1:0] prev_addr;
  logic [7:0] prev_wd;

  assign src_ack   = src_req;
  assign src_data  = img[src_addr];
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (clr_model) begin
      for (int a = 0; a < NADDR; a++) begin
        mem[a] <= 8'hFF;
        pcount[a] <= 0;
      end
      lowrun <= 0; bad_width <= 0; bad_stab <= 0; bad_level <= 0; vreads <= 0;
    end else begin
      if (!mem_pgm_n) begin
        lowrun <= lowrun + 1;
        if (!prog_level) bad_level <= bad_level + 1;
        if (prev_pgm && (prev_ce || prev_addr != mem_addr || prev_wd != mem_wdata))
          bad_stab <= bad_stab + 1;
        if (!prev_pgm && (prev_addr != mem_addr || prev_wd != mem_wdata || mem_ce_n))
          bad_stab <= bad_stab + 1;
      end else if (!prev_pgm) begin
        if (lowrun != EXP_PW) bad_width <= bad_width + 1;
        lowrun <= 0;
        if (mem_ce_n || mem_addr != prev_addr || mem_wdata != prev_wd) bad_stab <= bad_stab + 1;
        pcount[mem_addr] <= pcount[mem_addr] + 1;
        if (pcount[mem_addr] + 1 >= need[mem_addr]) mem[mem_addr] <= mem[mem_addr] & mem_wdata;
      end
      if (!mem_oe_n && !prog_level) vreads <= vreads + 1;
      if (prev_lvl && !prog_level && disturb_en) mem[7] <= mem[7] & 8'hFE;
    end
    prev_pgm  <= mem_pgm_n;
    prev_ce   <= mem_ce_n;
    prev_lvl  <= prog_level;
    prev_addr <= mem_addr;
    prev_wd   <= mem_wdata;
  end

  int nchk = 0, nerr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_defaults();
    for (int a = 0; a < NADDR; a++) begin
      img[a]  = 8'h5A ^ 8'(a * 19);
      need[a] = (a % 4) + 1;
    end
    disturb_en = 1'b0;
  endtask

  task automatic run(input int s, input int e, input bit poke);
    int cyc;
    @(negedge clk); clr_model = 1'b1;
    @(negedge clk); clr_model = 1'b0;
    start_addr = AW'(s); end_addr = AW'(e); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1 && pass == 1'b0 && fail == 1'b0, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start_addr = AW'(8); end_addr = AW'(9); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    cyc = 0;
    while (busy && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 20000, "watchdog run end", cyc, 20000);
  endtask

  // fail_at < 0: no address exhausts its retries
  task automatic expect_run(input int s, input int e, input int fail_at, input bit exp_pass,
                            input int exp_vreads, input string tag);
    int exp_p;
    logic [7:0] exp_m;
    chk(pass == exp_pass, {tag, " R8 pass"}, pass, exp_pass);
    chk(fail == !exp_pass, {tag, " R5 R8 fail"}, fail, !exp_pass);
    chk(bad_width == 0, {tag, " R2 strobe width"}, bad_width, 0);
    chk(bad_stab == 0, {tag, " R3 setup/hold"}, bad_stab, 0);
    chk(bad_level == 0, {tag, " R7 level in strobe"}, bad_level, 0);
    chk(vreads == exp_vreads, {tag, " R7 R8 verify reads"}, vreads, exp_vreads);
    for (int a = 0; a < NADDR; a++) begin
      if (a < s || a > e || (fail_at >= 0 && a > fail_at)) exp_p = 0;
      else if (a == fail_at) exp_p = MAX_TRIES;
      else exp_p = need[a];
      exp_m = (exp_p >= need[a] && exp_p > 0) ? img[a] : 8'hFF;
      if (disturb_en && a == 7) exp_m = exp_m & 8'hFE;
      chk(pcount[a] == exp_p, $sformatf("%s R4 R6 strobes at %0d", tag, a), pcount[a], exp_p);
      chk(mem[a] == exp_m, $sformatf("%s R4 cell %0d", tag, a), mem[a], exp_m);
    end
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual 150000 expected less");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    set_defaults();
    clr_model = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clr_model = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !pass && !fail && !prog_level && !src_req, "R1 status idle", {busy, pass, fail}, 0);
    chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_pgm_n}, 7);
    // R2 width in time lies inside 95..105 us
    chk(EXP_PW * (1_000_000_000 / CLK_HZ) >= 95_000 && EXP_PW * (1_000_000_000 / CLK_HZ) <= 105_000,
        "R2 width window ns", EXP_PW * (1_000_000_000 / CLK_HZ), 100_000);

    // full range, mixed retry needs
    run(0, NADDR - 1, 1'b0);
    expect_run(0, NADDR - 1, -1, 1'b1, NADDR, "full");
    repeat (20) @(negedge clk);
    chk(pass && !fail && !busy, "R10 result held", pass, 1);

    // lock byte only
    img[0] = 8'hFE;
    run(0, 0, 1'b0);
    expect_run(0, 0, -1, 1'b1, 1, "lock");
    set_defaults();

    // exactly the retry budget
    need[3] = MAX_TRIES;
    run(2, 4, 1'b0);
    expect_run(2, 4, -1, 1'b1, 3, "limit25");
    set_defaults();

    // one beyond the budget
    need[5] = MAX_TRIES + 1;
    run(4, 9, 1'b0);
    expect_run(4, 9, 5, 1'b0, 0, "limit26");
    set_defaults();

    // cell disturbed before the final pass
    disturb_en = 1'b1;
    run(0, NADDR - 1, 1'b0);
    expect_run(0, NADDR - 1, -1, 1'b0, 8, "disturb");
    set_defaults();

    // start pulse while busy must be ignored
    run(0, 5, 1'b1);
    expect_run(0, 5, -1, 1'b1, 6, "R9 poke");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule